// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Increment Pointer

This block is a slave on a two-wire serial bus (clock line and data line, both open-drain). It gives a bus host access to a bank of 128 eight-bit registers. A fast system clock oversamples both lines. After synchronizing them, the block finds the host's start and stop conditions and the clock edges. It then decodes a device-address byte, a register-address byte and any number of data bytes, writing them into the bank or reading them out of it.

The register-address byte carries a 7-bit register pointer and an auto-increment flag. With the flag set, the pointer steps on after each data byte and wraps from the top of the bank back to zero. With it clear, every data byte of the transfer uses the same register. The pointer survives a repeated start. A host can therefore set the pointer with a short write and then read from there. A combinational debug port lets the surrounding chip read any register directly.

The host paces every bit, so the serial side has no valid/ready handshake and no back-pressure. The debug port is a plain address-in, data-out read.

Top module: `twi_reg_slave`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. A stop returns the slave to idle with the data line released. Bytes clocked while idle are not acknowledged.
- R2: Bytes move most significant bit first, one bit per clock-line high period, and a ninth acknowledge slot follows each byte. In that slot 0 means ACK and 1 means NAK.
- R3: The first byte after a start carries the device address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). The slave ACKs only when the address equals its parameter. On a mismatch it NAKs, keeps the data line released, and ignores the bus until the next start or stop.
- R4: In a write, the second byte is the register-address byte: bit 7 is the auto-increment flag and bits 6..0 are the register pointer. The slave ACKs it.
- R5: Each further write byte is stored at the current pointer and ACKed.
- R6: With auto-increment set, the pointer advances by one after each data byte, whether written or read.
- R7: With auto-increment clear, the pointer stays put, so every data byte of the transfer hits the same register.
- R8: Advancing from pointer 0x7F gives 0x00.
- R9: In a read, the slave shifts out the register at the pointer, MSB first, and samples the host's acknowledge. An ACK makes it send the next byte. A NAK makes it release the data line and ignore the bus until the next start or stop.
- R10: A start seen without a stop before it returns the slave to the device-address phase with the data line released. The pointer and the auto-increment flag from an earlier write are kept.
- R11: Both lines pass through two-flop synchronizers. The slave drives the data line only through an output enable that pulls it low, and changes that enable only while the synchronized clock line is low.
- R12: Reset clears every register and releases the data line. The debug port returns the register selected by its address input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When 1, pull the data line low; when 0, release it |
| dbg_addr_i | input | 7 | Register index for the debug read |
| dbg_data_o | output | 8 | Contents of the register at dbg_addr_i |

## Verification
Two functions can land in the same system-clock cycle. The first is a bank write finishing on the falling clock edge that closes a data byte. The second is a pointer step at that same edge. When auto-increment is on and the pointer sits at 0x7F, the wrap to 0x00 coincides with the store into 0x7F. This is provoked directly by writing three bytes from 0x7E and by random transfers whose start pointers land near the top of the bank. It is judged through the debug port and a following read, both compared against a bench model of the bank and its pointer. A second collision is a repeated start arriving while the pointer is live. A read that follows it must begin at the retained pointer.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int unsigned DEV_AW = 7;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_REG,
    ST_WR,
    ST_RD,
    ST_SKIP
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int unsigned W       = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= {W{RST_VAL}};
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_p  = scl_q & scl_s & sda_q & ~sda_s;
  assign stop_p   = scl_q & scl_s & ~sda_q & sda_s;
  assign scl_rise = ~scl_q & scl_s;
  assign scl_fall = scl_q & ~scl_s;
endmodule

// File: rtl/twi_regbank.sv
module twi_regbank #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter logic [6:0]  DEV_ADDR = 7'h2A,
  parameter int unsigned REG_AW   = 7,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [REG_AW-1:0] dbg_addr_i,
  output logic [7:0]        dbg_data_o
);
  import twi_pkg::*;
  localparam int unsigned BW = BYTE_W;
  localparam int unsigned CW = $clog2(BW + 1);
  localparam logic [CW-1:0] FULL = CW'(BW);

  logic [1:0] lines_s;
  logic scl_s, sda_s;
  logic start_p, stop_p, scl_rise, scl_fall;

  twi_line_sync #(.W(2), .STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(lines_s));
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  twi_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_p(start_p), .stop_p(stop_p), .scl_rise(scl_rise), .scl_fall(scl_fall));

  twi_state_e       st_q;
  logic [CW-1:0]    cnt_q;
  logic             ack_ph_q, rw_q, ai_q, oe_q;
  logic [BW-1:0]    rx_q, tx_q, rd_byte;
  logic [REG_AW-1:0] ptr_q, ptr_next;
  logic             we, load_tx;

  assign ptr_next = ptr_q + REG_AW'(ai_q);
  assign we = (st_q == ST_WR) && scl_fall && !ack_ph_q && (cnt_q == FULL);
  assign load_tx = scl_fall && ack_ph_q &&
                   ((st_q == ST_DEV && rw_q) || st_q == ST_RD);

  twi_regbank #(.AW(REG_AW), .DW(BW)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(ptr_q), .wdata(rx_q),
    .raddr_a(ptr_q), .rdata_a(rd_byte),
    .raddr_b(dbg_addr_i), .rdata_b(dbg_data_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; ack_ph_q <= 1'b0; rw_q <= 1'b0;
      ai_q <= 1'b0; oe_q <= 1'b0; rx_q <= '0; tx_q <= '0; ptr_q <= '0;
    end else if (start_p) begin
      st_q <= ST_DEV; cnt_q <= '0; ack_ph_q <= 1'b0; oe_q <= 1'b0;
    end else if (stop_p) begin
      st_q <= ST_IDLE; cnt_q <= '0; ack_ph_q <= 1'b0; oe_q <= 1'b0;
    end else if (load_tx) begin
      st_q <= ST_RD; ack_ph_q <= 1'b0;
      oe_q <= ~rd_byte[BW-1];
      tx_q <= {rd_byte[BW-2:0], 1'b0};
      cnt_q <= CW'(1);
      ptr_q <= ptr_next;
    end else begin
      unique case (st_q)
        ST_DEV, ST_REG, ST_WR: begin
          if (scl_rise && !ack_ph_q && cnt_q != FULL) begin
            rx_q  <= {rx_q[BW-2:0], sda_s};
            cnt_q <= cnt_q + CW'(1);
          end
          if (scl_fall) begin
            if (ack_ph_q) begin
              ack_ph_q <= 1'b0; oe_q <= 1'b0; cnt_q <= '0;
              if (st_q == ST_DEV) st_q <= ST_REG;
              else if (st_q == ST_REG) st_q <= ST_WR;
            end else if (cnt_q == FULL) begin
              if (st_q == ST_DEV) begin
                if (rx_q[BW-1:1] == DEV_ADDR) begin
                  rw_q <= rx_q[0]; oe_q <= 1'b1; ack_ph_q <= 1'b1;
                end else begin
                  st_q <= ST_SKIP;
                end
              end else begin
                if (st_q == ST_REG) begin
                  ai_q  <= rx_q[BW-1];
                  ptr_q <= rx_q[REG_AW-1:0];
                end else begin
                  ptr_q <= ptr_next;
                end
                oe_q <= 1'b1; ack_ph_q <= 1'b1;
              end
            end
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q != FULL) begin
              oe_q  <= ~tx_q[BW-1];
              tx_q  <= {tx_q[BW-2:0], 1'b0};
              cnt_q <= cnt_q + CW'(1);
            end else begin
              oe_q <= 1'b0; ack_ph_q <= 1'b1;
            end
          end
          if (scl_rise && ack_ph_q && sda_s) st_q <= ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  assert_oe_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);
  assert_skip_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SKIP) |-> !sda_oe_o);
  assert_restart_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (st_q == ST_DEV && !sda_oe_o));
  assert_stop_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> (st_q == ST_IDLE && !sda_oe_o));
  assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ai_q && ptr_q == '1) |=> (ptr_q == '0));
  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !ai_q) |=> $stable(ptr_q));
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ai_q) |=> (ptr_q == $past(ptr_q) + REG_AW'(1)));
endmodule

// File: tb/tb_twi_reg_slave.sv
`timescale 1ns/1ps
module tb_twi_reg_slave;
  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1, host_sda = 1'b1;
  logic sda_oe;
  logic [6:0] dbg_addr = '0;
  logic [7:0] dbg_data;
  wire sda_bus = host_sda & ~sda_oe;

  always #10 clk = ~clk;

  twi_reg_slave #(.DEV_ADDR(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data));

  int n_chk = 0, n_err = 0, r11_bad = 0;
  logic [7:0] model [128];
  logic [7:0] wbuf [4];
  logic oe_prev = 1'b0;

  always @(posedge clk) begin
    if (rst_n && sda_oe !== oe_prev && host_scl) r11_bad++;
    oe_prev <= sda_oe;
  end

  function automatic logic [6:0] step(input logic [6:0] p, input logic ai);
    return ai ? p + 7'd1 : p;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q(); repeat (6) @(negedge clk); endtask

  task automatic bit_slot(input logic b, output logic s);
    host_sda = b; q(); host_scl = 1'b1; q(); s = sda_bus; q(); host_scl = 1'b0; q();
  endtask

  task automatic bus_start();
    if (!host_scl) begin host_sda = 1'b1; q(); host_scl = 1'b1; q(); end
    host_sda = 1'b0; q(); host_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; q(); host_scl = 1'b1; q(); host_sda = 1'b1; q(); q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_slot(b[i], s);
    bit_slot(1'b1, ack);
  endtask

  task automatic recv_byte(input logic nak, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) bit_slot(1'b1, b[i]);
    bit_slot(nak, s);
  endtask

  task automatic dbg_chk(input logic [6:0] a, input string req);
    dbg_addr = a; @(negedge clk);
    check(req, dbg_data, model[a]);
  endtask

  task automatic do_write(input logic [6:0] ra, input logic ai, input int len, input string req);
    logic ack; logic [6:0] p;
    bus_start();
    send_byte({DEV, 1'b0}, ack); check("R2 dev ack", ack, 1'b0);
    send_byte({ai, ra}, ack);    check("R4 reg ack", ack, 1'b0);
    p = ra;
    for (int k = 0; k < len; k++) begin
      send_byte(wbuf[k], ack); check({"R5 data ack ", req}, ack, 1'b0);
      model[p] = wbuf[k]; p = step(p, ai);
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] ra, input logic ai, input int len, input string req);
    logic ack; logic [6:0] p; logic [7:0] b;
    bus_start();
    send_byte({DEV, 1'b0}, ack); check("R2 dev ack", ack, 1'b0);
    send_byte({ai, ra}, ack);    check("R4 reg ack", ack, 1'b0);
    bus_start();
    send_byte({DEV, 1'b1}, ack); check("R10 restart dev ack", ack, 1'b0);
    p = ra;
    for (int k = 0; k < len; k++) begin
      recv_byte(k == len - 1, b);
      check({"R9 read ", req}, b, model[p]);
      p = step(p, ai);
    end
    check("R9 released after NAK", sda_oe, 1'b0);
    recv_byte(1'b1, b); check("R9 ignores after NAK", b, 8'hFF);
    bus_stop();
  endtask

  initial begin
    logic ack; logic [7:0] b;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 reset oe", sda_oe, 1'b0);
    dbg_chk(7'h00, "R12 reset reg0");
    dbg_chk(7'h7F, "R12 reset reg7F");

    // R6 auto-increment write from 0x01
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    do_write(7'h01, 1'b1, 3, "R6");
    dbg_chk(7'h01, "R6 reg01"); dbg_chk(7'h02, "R6 reg02"); dbg_chk(7'h03, "R6 reg03");

    // R7 fixed pointer write
    wbuf[0] = 8'h5A; wbuf[1] = 8'h3C;
    do_write(7'h10, 1'b0, 2, "R7");
    dbg_chk(7'h10, "R7 reg10 holds last"); dbg_chk(7'h11, "R7 reg11 untouched");

    // R8 wrap at top of bank
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(7'h7E, 1'b1, 3, "R8");
    dbg_chk(7'h7F, "R8 reg7F"); dbg_chk(7'h00, "R8 reg00 after wrap");

    // R3 address mismatch
    bus_start();
    send_byte({7'h15, 1'b0}, ack); check("R3 mismatch NAK", ack, 1'b1);
    send_byte(8'h85, ack);         check("R3 ignored reg byte", ack, 1'b1);
    send_byte(8'h99, ack);         check("R3 ignored data byte", ack, 1'b1);
    bus_stop();
    dbg_chk(7'h05, "R3 reg05 untouched");

    // R1 byte without start is not acknowledged
    host_scl = 1'b0; q();
    send_byte({DEV, 1'b0}, ack); check("R1 idle no ack", ack, 1'b1);
    bus_stop();

    // R9/R10 reads
    do_read(7'h01, 1'b1, 3, "ai");
    do_read(7'h10, 1'b0, 2, "fixed");
    do_read(7'h7F, 1'b1, 2, "wrap R8");

    // random mix
    for (int t = 0; t < 20; t++) begin
      logic [6:0] ra; logic ai; int len;
      ra = 7'($urandom); ai = 1'($urandom); len = 1 + int'($urandom % 4);
      if (t % 4 == 0) ra = 7'h7C + 7'($urandom % 4);
      for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
      do_write(ra, ai, len, "rand");
      dbg_chk(ra, "R5 rand dbg");
      if (t % 3 == 0) do_read(ra, ai, len, "rand");
    end

    check("R11 oe changes only with scl low", r11_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule